// File: doc/BRIEF.md
# APB UART Register and Receive-Queue Front-End

This block is the processor-facing half of a UART. It sits on an APB bus and exposes a 32-bit data port, a read-only status word, a fully writable control word and a scaler slot that always reads zero. Received bytes come in on a byte-stream input with a valid/ready handshake. While receiving is enabled they are queued in a receive FIFO whose depth is a parameter. The processor drains the queue by reading the data port. Writing the data port sends the low byte out on a byte-stream output as a single-cycle strobe, provided transmitting is enabled.

One interrupt line carries a one-cycle pulse for every byte that is queued or sent, each gated by its own enable bit. The serial shifter, baud generation, parity, break and flow control all live outside this block. The status bits that belong to them read as idle.

Top module: `uart_regfront`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000_0006, irq_o and tx_valid_o are low and rx_ready_o is high.
- R2: The control word at offset 0x08 holds all 32 bits that are written to it and reads them back unchanged. Bit 0 enables receive, bit 1 enables transmit, bit 2 enables the receive interrupt and bit 3 enables the transmit interrupt.
- R3: The status word at offset 0x04 is read-only, and writes to it have no effect. Bits 1 (transmit shifter empty) and 2 (transmit queue empty) always read 1. Bits 3 to 7, bit 9 and bits 11 to 31 always read 0.
- R4: The scaler offset 0x0C, the debug offset 0x10 and every other unmapped offset read 0 and ignore writes.
- R5: A handshaked input byte taken while control bit 0 is set is queued, and status bit 0 (data ready) reads 1 while the queue holds at least one byte.
- R6: A handshaked input byte taken while control bit 0 is clear completes its handshake but is discarded: it is not queued and it raises no interrupt.
- R7: A read at offset 0x00 or 0x03 returns the oldest queued byte in bits 7:0, with bits 31:8 zero, and removes exactly that byte. On an empty queue it returns 0. Status bit 0 clears once the last byte has been read.
- R8: rx_ready_o is low exactly while the queue holds DEPTH bytes. Status bit 10 reads 1 when the queue is full, and status bit 8 reads 1 when it holds at least DEPTH/2 bytes.
- R9: A write at offset 0x00 or 0x03 while control bit 1 is set raises tx_valid_o for exactly the following cycle, with pwdata_i[7:0] on tx_data_o. While bit 1 is clear there is no strobe.
- R10: irq_o pulses high for one cycle, in the cycle after a byte is queued with control bit 2 set or a byte is sent with control bit 3 set. At all other times irq_o stays low.
- R11: pready_o is always high, so every access completes without wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Receive queue can take a byte |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Single-cycle outgoing byte strobe |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The assertions check on every cycle that the queue is never pushed while full and never exceeds its depth, and that a read from an empty queue leaves it empty. They also check that data ready only rises after a queued byte, that an interrupt or transmit strobe only follows a cycle in which the matching enable was set, and that the control word changes only on a control write. Only the bench scenarios can show the byte order through the queue, the alias of the data port at offset 3, the reset values and the exact status encoding, the half and full thresholds, and that discarded bytes and writes to the status, scaler or unmapped offsets leave no trace.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DATA_B = 8'h03;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_SCAL   = 8'h0C;

  // status bit positions
  localparam int unsigned ST_DRDY  = 0;
  localparam int unsigned ST_TSE   = 1;
  localparam int unsigned ST_TFE   = 2;
  localparam int unsigned ST_RHALF = 8;
  localparam int unsigned ST_RFULL = 10;

  // control bit positions
  localparam int unsigned CT_RXEN = 0;
  localparam int unsigned CT_TXEN = 1;
  localparam int unsigned CT_RXIE = 2;
  localparam int unsigned CT_TXIE = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_SCAL
  } reg_sel_e;
endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
  import uart_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFF_DATA) || addr_i == ADDR_W'(OFF_DATA_B)) sel_o = SEL_DATA;
    else if (addr_i == ADDR_W'(OFF_STAT)) sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFF_CTRL)) sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFF_SCAL)) sel_o = SEL_SCAL;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = PTR_W + 1;
  localparam int unsigned HALF  = DEPTH / 2;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign half_o  = (cnt_q >= CNT_W'(HALF));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R7
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/uart_irq_pulse.sv
module uart_irq_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_evt_i,
  input  logic rx_ie_i,
  input  logic tx_evt_i,
  input  logic tx_ie_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (rx_evt_i & rx_ie_i) | (tx_evt_i & tx_ie_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [REG_W-1:0]  pwdata_i,
  output logic [REG_W-1:0]  prdata_o,
  output logic              pready_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              acc, wr, rd;
  logic [REG_W-1:0]  ctrl_q, status;
  logic              ctrl_wr, rx_push, rx_pop, tx_fire;
  logic [BYTE_W-1:0] rx_head, tx_data_q;
  logic              rx_empty, rx_full, rx_half, tx_valid_q;

  uart_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(paddr_i), .sel_o(sel));

  assign acc      = psel_i & penable_i;
  assign wr       = acc & pwrite_i;
  assign rd       = acc & ~pwrite_i;
  assign ctrl_wr  = wr & (sel == SEL_CTRL);
  assign rx_ready_o = ~rx_full;
  // bytes taken while receive is off are drained and dropped
  assign rx_push  = rx_valid_i & rx_ready_o & ctrl_q[CT_RXEN];
  assign rx_pop   = rd & (sel == SEL_DATA);
  assign tx_fire  = wr & (sel == SEL_DATA) & ctrl_q[CT_TXEN];
  assign pready_o = 1'b1;

  uart_rx_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .din_i   (rx_data_i),
    .pop_i   (rx_pop),
    .dout_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .half_o  (rx_half)
  );

  uart_irq_pulse u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_evt_i (rx_push),
    .rx_ie_i  (ctrl_q[CT_RXIE]),
    .tx_evt_i (tx_fire),
    .tx_ie_i  (ctrl_q[CT_TXIE]),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= pwdata_i;
      tx_valid_q <= tx_fire;
      if (tx_fire) tx_data_q <= pwdata_i[BYTE_W-1:0];
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  always_comb begin
    status           = '0;
    status[ST_DRDY]  = ~rx_empty;
    status[ST_TSE]   = 1'b1;
    status[ST_TFE]   = 1'b1;
    status[ST_RHALF] = rx_half;
    status[ST_RFULL] = rx_full;
  end

  always_comb begin
    case (sel)
      SEL_DATA: prdata_o = REG_W'(rx_head);
      SEL_STAT: prdata_o = status;
      SEL_CTRL: prdata_o = ctrl_q;
      default:  prdata_o = '0;
    endcase
  end

  // R5
  drdy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[ST_DRDY]) |-> $past(rx_push));
  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl_q[CT_RXIE] | ctrl_q[CT_TXIE]));
  // R9
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(ctrl_q[CT_TXEN]));
  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q));
endmodule

// File: tb/uart_regfront_test.sv
`timescale 1ns/1ps
module uart_regfront_test;
  localparam int unsigned DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  q[$];
  logic [31:0] ctrl_m = '0;

  always #10 clk = ~clk;

  uart_regfront #(.ADDR_W(8), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .irq_o(irq)
  );

  function automatic logic [31:0] exp_status(int cnt);
    logic [31:0] s = 32'h6;
    s[0]  = (cnt != 0);
    s[8]  = (cnt >= DEPTH/2);
    s[10] = (cnt == DEPTH);
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // returns tx strobe/data and irq after the access edge, and tx strobe one cycle later
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d,
                        output logic tv, output logic [7:0] td, output logic ir, output logic tv2);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    tv = tx_valid; td = tx_data; ir = irq;
    @(negedge clk); tv2 = tx_valid;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rx_send(input logic [7:0] b, output logic rdy, output logic ir);
    @(negedge clk); rx_valid = 1; rx_data = b;
    rdy = rx_ready;
    @(negedge clk); rx_valid = 0;
    ir = irq;
  endtask

  // model-driven operations
  task automatic do_ctrl(input logic [31:0] v);
    logic tv, ir, tv2; logic [7:0] td;
    apb_wr(8'h08, v, tv, td, ir, tv2);
    ctrl_m = v;
    chk("R10 ctrl write irq", 32'(ir), 0);
  endtask

  task automatic do_rx(input logic [7:0] b);
    logic rdy, ir, acc;
    rx_send(b, rdy, ir);
    chk("R8 rx_ready", 32'(rdy), 32'(q.size() < DEPTH));
    acc = (q.size() < DEPTH) && ctrl_m[0];
    if (acc) q.push_back(b);
    chk("R10/R6 rx irq", 32'(ir), 32'(acc && ctrl_m[2]));
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [31:0] d, e;
    apb_rd(a, d);
    e = 0;
    if (q.size() > 0) e = 32'(q.pop_front());
    chk("R7 data read", d, e);
  endtask

  task automatic do_tx(input logic [7:0] a, input logic [31:0] v);
    logic tv, ir, tv2; logic [7:0] td;
    apb_wr(a, v, tv, td, ir, tv2);
    chk("R9 tx strobe", 32'(tv), 32'(ctrl_m[1]));
    if (ctrl_m[1]) chk("R9 tx data", 32'(td), 32'(v[7:0]));
    chk("R9 tx single cycle", 32'(tv2), 0);
    chk("R10 tx irq", 32'(ir), 32'(ctrl_m[1] && ctrl_m[3]));
  endtask

  task automatic chk_status(string req);
    logic [31:0] d;
    apb_rd(8'h04, d);
    chk(req, d, exp_status(q.size()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic tv, ir, tv2; logic [7:0] td;
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    chk("R11 pready", 32'(pready), 1);
    apb_rd(8'h08, d); chk("R1 ctrl", d, 0);
    apb_rd(8'h04, d); chk("R1 status", d, 32'h6);

    // R6 receive disabled: byte drained and dropped
    do_rx(8'hA5);
    chk_status("R6 status after discard");
    do_read(8'h00);

    // R2 full readback
    do_ctrl(32'hFFFF_FFFF);
    apb_rd(8'h08, d); chk("R2 ctrl all ones", d, 32'hFFFF_FFFF);
    do_ctrl(32'h8000_1235);
    apb_rd(8'h08, d); chk("R2 ctrl pattern", d, 32'h8000_1235);

    // R5/R7 queue order, alias at offset 3
    do_ctrl(32'h5);
    do_rx(8'h11); do_rx(8'h22); do_rx(8'h33);
    chk_status("R5 data ready");
    do_read(8'h03); do_read(8'h00);
    chk_status("R5 data ready with one left");
    do_read(8'h03);
    chk_status("R7 data ready cleared");
    do_read(8'h00);

    // R3 status write ignored
    do_rx(8'h44);
    apb_wr(8'h04, 32'hFFFF_FFFF, tv, td, ir, tv2);
    chk_status("R3 status read-only");
    do_read(8'h00);

    // R4 scaler and unmapped
    apb_wr(8'h0C, 32'hDEAD_BEEF, tv, td, ir, tv2);
    apb_rd(8'h0C, d); chk("R4 scaler", d, 0);
    apb_wr(8'h10, 32'h1234_5678, tv, td, ir, tv2);
    apb_rd(8'h10, d); chk("R4 debug offset", d, 0);
    apb_rd(8'h14, d); chk("R4 unmapped", d, 0);
    apb_rd(8'h08, d); chk("R4 ctrl untouched", d, 32'h5);

    // R8 half and full thresholds
    for (int i = 0; i < DEPTH; i++) begin
      do_rx(8'(i * 7 + 1));
      if (i + 1 == DEPTH/2 - 1 || i + 1 == DEPTH/2 || i + 1 == DEPTH)
        chk_status("R8 occupancy status");
    end
    chk("R8 rx_ready full", 32'(rx_ready), 0);
    do_rx(8'hEE);
    for (int i = 0; i < DEPTH; i++) do_read(8'h00);
    chk_status("R8 drained");

    // R9/R10 transmit
    do_ctrl(32'h2);
    do_tx(8'h00, 32'hABCD_EF5A);
    do_tx(8'h03, 32'h0000_00C3);
    do_ctrl(32'hA);
    do_tx(8'h00, 32'h0000_0077);
    do_ctrl(32'h8);
    do_tx(8'h00, 32'h0000_0099);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 4)       do_rx(8'($urandom));
      else if (op < 7)  do_read(($urandom % 2) ? 8'h03 : 8'h00);
      else if (op < 8)  do_ctrl($urandom);
      else if (op < 9)  do_tx(($urandom % 2) ? 8'h03 : 8'h00, $urandom);
      else              chk_status("R3/R8 random status");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule